// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block tracks one processor's address reservation so that a load-reserved / store-conditional pair can behave atomically. A load-reserved request records its address and arms the reservation. A later store-conditional request is judged against that reservation. The block reports whether the store may go to memory (`sc_commit`) and returns a status code that is zero on success and non-zero on failure. Software retries the pair in a loop until the status is zero.

The reservation is lost when any of these happens:
- another agent writes the tracked block;
- the cache block holding it is invalidated;
- an interrupt occurs;
- a context switch occurs;
- any store-conditional executes.

Addresses are compared per cache block. The low `OFS` address bits select a byte within a block and are ignored by the comparison. The memory, the pipeline and the cache are outside this block. Results are registered and appear one clock after the store-conditional request.

Top module: `lrsc_resv_monitor`

## Requirements
- R1: After a synchronous reset there is no reservation, and `sc_done`, `sc_commit` and `sc_status` are all 0.
- R2: After a load-reserved, a store-conditional to the same block with no kill event gives, in the next cycle, `sc_done`=1, `sc_commit`=1 and `sc_status`=0.
- R3: A snooped foreign write to the reserved block clears the reservation. A foreign write to any other block leaves the reservation intact.
- R4: A snooped invalidation of the reserved block clears the reservation. An invalidation of another block leaves it intact.
- R5: A pulse on `irq_clr` or on `ctx_clr` clears the reservation.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails. A second store-conditional then fails with status 1.
- R7: A new load-reserved replaces the earlier reservation. A store-conditional to the old block then fails with status 2.
- R8: A kill event in the same cycle as a store-conditional makes the store fail with status 3. This applies only when the store would otherwise have succeeded.
- R9: A store-conditional with no reservation fails with status 1. A store-conditional to a different block fails with status 2. Status precedence is 1 over 2 over 3, and `sc_commit` is 0 on every failure.
- R10: Matching is per block. A store-conditional to any byte within the reserved block is treated as a match.
- R11: A load-reserved in the same cycle as a kill event or a store-conditional still arms a fresh reservation. The kill or the store acts only on the old reservation.
- R12: In a cycle that does not follow a store-conditional request, `sc_done`, `sc_commit` and `sc_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_valid | input | 1 | Load-reserved request |
| lr_addr | input | AW | Load-reserved address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | AW | Store-conditional address |
| snp_wr_valid | input | 1 | Foreign write observed |
| snp_wr_addr | input | AW | Address of the foreign write |
| snp_inv_valid | input | 1 | Cache block invalidation observed |
| snp_inv_addr | input | AW | Address of the invalidated block |
| irq_clr | input | 1 | Interrupt clear pulse |
| ctx_clr | input | 1 | Context-switch clear pulse |
| sc_done | output | 1 | Store-conditional result valid (one cycle after request) |
| sc_commit | output | 1 | Store may be written to memory |
| sc_status | output | 2 | 0 = success, 1 = no reservation, 2 = block mismatch, 3 = killed in same cycle |

## Verification
A store-conditional and a kill event can fall in the same clock cycle. So can a load-reserved and a kill or a store. The bench drives these pairs deliberately in directed steps. It also drives a long random stream over a handful of block addresses, so that snooped writes and invalidations often hit the reserved block in the very cycle a store-conditional is checked. Each outcome is judged against a behavioural model. In that model, the store is evaluated against the old reservation and the kill wins over the store. A simultaneous load-reserved then arms a new reservation.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int STW = 2;

  typedef enum logic [STW-1:0] {
    ST_OK       = 2'd0,
    ST_NORESV   = 2'd1,
    ST_MISMATCH = 2'd2,
    ST_KILLED   = 2'd3
  } sc_stat_e;

  typedef struct packed {
    logic       commit;
    sc_stat_e   status;
  } sc_verdict_t;
endpackage

// File: rtl/lrsc_blk_cmp.sv
module lrsc_blk_cmp #(
  parameter int AW  = 16,
  parameter int OFS = 4
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic          same_blk
);
  localparam logic [AW-1:0] BLK_MASK = {AW{1'b1}} << OFS;

  // R10: offset bits are masked out of the comparison
  assign same_blk = ((a ^ b) & BLK_MASK) == '0;
endmodule

// File: rtl/lrsc_kill_unit.sv
module lrsc_kill_unit #(
  parameter int AW  = 16,
  parameter int OFS = 4,
  parameter int NSNP = 2
) (
  input  logic [NSNP-1:0]         snp_vld,
  input  logic [NSNP-1:0][AW-1:0] snp_addr,
  input  logic [AW-1:0]           resv_addr,
  input  logic                    irq_clr,
  input  logic                    ctx_clr,
  output logic                    kill
);
  logic [NSNP-1:0] hit;

  // R3, R4: one block comparator per snoop source
  for (genvar i = 0; i < NSNP; i++) begin : g_snp
    logic m;
    lrsc_blk_cmp #(.AW(AW), .OFS(OFS)) u_cmp (
      .a(snp_addr[i]), .b(resv_addr), .same_blk(m)
    );
    assign hit[i] = snp_vld[i] & m;
  end

  // R5: asynchronous-to-the-program clears
  assign kill = (|hit) | irq_clr | ctx_clr;
endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [AW-1:0] arm_addr,
  input  logic          drop,
  output logic          valid,
  output logic [AW-1:0] addr
);
  // R11: arming takes precedence over a drop in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
    end else if (arm) begin
      valid <= 1'b1;
      addr  <= arm_addr;
    end else if (drop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lrsc_resv_monitor.sv
module lrsc_resv_monitor
  import lrsc_pkg::*;
#(
  parameter int AW  = 16,
  parameter int OFS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lr_valid,
  input  logic [AW-1:0] lr_addr,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic          snp_wr_valid,
  input  logic [AW-1:0] snp_wr_addr,
  input  logic          snp_inv_valid,
  input  logic [AW-1:0] snp_inv_addr,
  input  logic          irq_clr,
  input  logic          ctx_clr,
  output logic          sc_done,
  output logic          sc_commit,
  output logic [STW-1:0] sc_status
);
  localparam int NSNP = 2;

  logic                    rv_valid;
  logic [AW-1:0]           rv_addr;
  logic                    kill_now;
  logic                    sc_match;
  logic [NSNP-1:0]         snp_vld;
  logic [NSNP-1:0][AW-1:0] snp_addr;
  sc_verdict_t             verdict;

  assign snp_vld  = {snp_inv_valid, snp_wr_valid};
  assign snp_addr = {snp_inv_addr, snp_wr_addr};

  lrsc_kill_unit #(.AW(AW), .OFS(OFS), .NSNP(NSNP)) u_kill (
    .snp_vld(snp_vld), .snp_addr(snp_addr), .resv_addr(rv_addr),
    .irq_clr(irq_clr), .ctx_clr(ctx_clr), .kill(kill_now)
  );

  lrsc_blk_cmp #(.AW(AW), .OFS(OFS)) u_sc_cmp (
    .a(sc_addr), .b(rv_addr), .same_blk(sc_match)
  );

  // R6: any SC drops the reservation; R3-R5 via kill
  lrsc_resv_reg #(.AW(AW)) u_resv (
    .clk(clk), .rst(rst),
    .arm(lr_valid), .arm_addr(lr_addr),
    .drop(sc_valid | kill_now),
    .valid(rv_valid), .addr(rv_addr)
  );

  // R8, R9: status precedence no-reservation, mismatch, killed
  always_comb begin
    verdict = '{commit: 1'b0, status: ST_OK};
    if (!rv_valid)      verdict.status = ST_NORESV;
    else if (!sc_match) verdict.status = ST_MISMATCH;
    else if (kill_now)  verdict.status = ST_KILLED;
    else                verdict.commit = 1'b1;
  end

  // R2, R12: registered result, zero outside result cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      sc_done   <= 1'b0;
      sc_commit <= 1'b0;
      sc_status <= '0;
    end else begin
      sc_done   <= sc_valid;
      sc_commit <= sc_valid & verdict.commit;
      sc_status <= sc_valid ? verdict.status : ST_OK;
    end
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int AW  = 16,
  parameter int OFS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          lr_valid,
  input logic          sc_valid,
  input logic [AW-1:0] sc_addr,
  input logic          snp_wr_valid,
  input logic [AW-1:0] snp_wr_addr,
  input logic          snp_inv_valid,
  input logic [AW-1:0] snp_inv_addr,
  input logic          irq_clr,
  input logic          ctx_clr,
  input logic          sc_done,
  input logic          sc_commit,
  input logic [1:0]    sc_status
);
  localparam int TW = AW - OFS;

  p_done_follows_r2: assert property (@(posedge clk) disable iff (rst)
    sc_valid |=> sc_done);
  p_commit_ok_r2: assert property (@(posedge clk) disable iff (rst)
    sc_commit |-> (sc_done && sc_status == 2'd0));
  p_fail_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    (sc_done && !sc_commit) |-> sc_status != 2'd0);
  p_wr_kill_r3: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && snp_wr_valid && snp_wr_addr[AW-1 -: TW] == sc_addr[AW-1 -: TW])
      |=> !sc_commit);
  p_inv_kill_r4: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && snp_inv_valid && snp_inv_addr[AW-1 -: TW] == sc_addr[AW-1 -: TW])
      |=> !sc_commit);
  p_clr_kill_r5: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && (irq_clr || ctx_clr)) |=> !sc_commit);
  p_sc_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !lr_valid) ##1 sc_valid |=> !sc_commit);
  p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !sc_done |-> (!sc_commit && sc_status == 2'd0));
endmodule

bind lrsc_resv_monitor lrsc_monitor_chk #(.AW(AW), .OFS(OFS)) u_chk (
  .clk(clk), .rst(rst), .lr_valid(lr_valid), .sc_valid(sc_valid),
  .sc_addr(sc_addr), .snp_wr_valid(snp_wr_valid), .snp_wr_addr(snp_wr_addr),
  .snp_inv_valid(snp_inv_valid), .snp_inv_addr(snp_inv_addr),
  .irq_clr(irq_clr), .ctx_clr(ctx_clr), .sc_done(sc_done),
  .sc_commit(sc_commit), .sc_status(sc_status)
);

// File: tb/sim_lrsc_resv_monitor.sv
module sim_lrsc_resv_monitor;
  localparam int AW  = 16;
  localparam int OFS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lr_valid = 0, sc_valid = 0, snp_wr_valid = 0, snp_inv_valid = 0;
  logic irq_clr = 0, ctx_clr = 0;
  logic [AW-1:0] lr_addr = '0, sc_addr = '0, snp_wr_addr = '0, snp_inv_addr = '0;
  logic sc_done, sc_commit;
  logic [1:0] sc_status;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  // reference state
  bit m_valid = 0;
  int m_blk = 0;
  bit e_done = 0, e_commit = 0;
  int e_status = 0;

  always #10 clk = ~clk;

  lrsc_resv_monitor #(.AW(AW), .OFS(OFS)) u0 (
    .clk(clk), .rst(rst),
    .lr_valid(lr_valid), .lr_addr(lr_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr),
    .snp_wr_valid(snp_wr_valid), .snp_wr_addr(snp_wr_addr),
    .snp_inv_valid(snp_inv_valid), .snp_inv_addr(snp_inv_addr),
    .irq_clr(irq_clr), .ctx_clr(ctx_clr),
    .sc_done(sc_done), .sc_commit(sc_commit), .sc_status(sc_status)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  task automatic chk(string tag);
    checks += 3;
    if (sc_done !== e_done) begin
      errors++;
      $display("FAIL %s sc_done actual=%0d expected=%0d", tag, sc_done, e_done);
    end
    if (sc_commit !== e_commit) begin
      errors++;
      $display("FAIL %s sc_commit actual=%0d expected=%0d", tag, sc_commit, e_commit);
    end
    if (int'(sc_status) !== e_status) begin
      errors++;
      $display("FAIL %s sc_status actual=%0d expected=%0d", tag, sc_status, e_status);
    end
  endtask

  // one clock: drive at negedge, predict, compare at next negedge
  task automatic cyc(bit lr, int la, bit sc, int sa, bit w, int wa,
                     bit iv, int ia, bit irq, bit ctx, string tag);
    bit killed;
    lr_valid = lr; lr_addr = AW'(la);
    sc_valid = sc; sc_addr = AW'(sa);
    snp_wr_valid = w; snp_wr_addr = AW'(wa);
    snp_inv_valid = iv; snp_inv_addr = AW'(ia);
    irq_clr = irq; ctx_clr = ctx;
    killed = irq || ctx || (w && ((wa >> OFS) == m_blk)) || (iv && ((ia >> OFS) == m_blk));
    e_done = sc; e_commit = 0; e_status = 0;
    if (sc) begin
      if (!m_valid) e_status = 1;
      else if ((sa >> OFS) != m_blk) e_status = 2;
      else if (killed) e_status = 3;
      else e_commit = 1;
    end
    if (lr) begin m_valid = 1; m_blk = la >> OFS; end
    else if (sc || killed) m_valid = 0;
    @(negedge clk);
    chk(tag);
  endtask

  task automatic idle(string tag);
    cyc(0,0, 0,0, 0,0, 0,0, 0,0, tag);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    checks += 3;
    if (sc_done !== 0 || sc_commit !== 0 || sc_status !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0d%0d%0d expected=000", sc_done, sc_commit, sc_status);
    end
    rst = 0;
    // R1: SC right after reset finds no reservation
    cyc(0,0, 1,16'h0100, 0,0, 0,0, 0,0, "R1");
    idle("R12");
    // R2: basic success
    cyc(1,16'h0120, 0,0, 0,0, 0,0, 0,0, "R2");
    idle("R12");
    cyc(0,0, 1,16'h0120, 0,0, 0,0, 0,0, "R2");
    // R6: second SC fails
    cyc(0,0, 1,16'h0120, 0,0, 0,0, 0,0, "R6");
    // R10: other byte in same block
    cyc(1,16'h0230, 0,0, 0,0, 0,0, 0,0, "R10");
    cyc(0,0, 1,16'h023F, 0,0, 0,0, 0,0, "R10");
    // R3: foreign write other block keeps, same block kills
    cyc(1,16'h0340, 0,0, 0,0, 0,0, 0,0, "R3");
    cyc(0,0, 0,0, 1,16'h0350, 0,0, 0,0, "R3");
    cyc(0,0, 1,16'h0340, 0,0, 0,0, 0,0, "R3");
    cyc(1,16'h0340, 0,0, 0,0, 0,0, 0,0, "R3");
    cyc(0,0, 0,0, 1,16'h0347, 0,0, 0,0, "R3");
    cyc(0,0, 1,16'h0340, 0,0, 0,0, 0,0, "R3");
    // R4: invalidation
    cyc(1,16'h0400, 0,0, 0,0, 0,0, 0,0, "R4");
    cyc(0,0, 0,0, 0,0, 1,16'h0410, 0,0, "R4");
    cyc(0,0, 1,16'h0400, 0,0, 0,0, 0,0, "R4");
    cyc(1,16'h0400, 0,0, 0,0, 0,0, 0,0, "R4");
    cyc(0,0, 0,0, 0,0, 1,16'h040C, 0,0, "R4");
    cyc(0,0, 1,16'h0400, 0,0, 0,0, 0,0, "R4");
    // R5: interrupt and context switch
    cyc(1,16'h0500, 0,0, 0,0, 0,0, 0,0, "R5");
    cyc(0,0, 0,0, 0,0, 0,0, 1,0, "R5");
    cyc(0,0, 1,16'h0500, 0,0, 0,0, 0,0, "R5");
    cyc(1,16'h0500, 0,0, 0,0, 0,0, 0,0, "R5");
    cyc(0,0, 0,0, 0,0, 0,0, 0,1, "R5");
    cyc(0,0, 1,16'h0500, 0,0, 0,0, 0,0, "R5");
    // R7: replacement then SC to old block -> status 2
    cyc(1,16'h0600, 0,0, 0,0, 0,0, 0,0, "R7");
    cyc(1,16'h0700, 0,0, 0,0, 0,0, 0,0, "R7");
    cyc(0,0, 1,16'h0600, 0,0, 0,0, 0,0, "R7");
    // R9: mismatch beats kill in precedence
    cyc(1,16'h0800, 0,0, 0,0, 0,0, 0,0, "R9");
    cyc(0,0, 1,16'h0900, 0,0, 0,0, 1,0, "R9");
    // R8: kill same cycle as SC
    cyc(1,16'h0A00, 0,0, 0,0, 0,0, 0,0, "R8");
    cyc(0,0, 1,16'h0A00, 1,16'h0A04, 0,0, 0,0, "R8");
    cyc(1,16'h0A00, 0,0, 0,0, 0,0, 0,0, "R8");
    cyc(0,0, 1,16'h0A00, 0,0, 0,0, 0,1, "R8");
    // R11: LR together with kill, then SC succeeds
    cyc(1,16'h0B00, 0,0, 1,16'h0B00, 0,0, 1,0, "R11");
    cyc(0,0, 1,16'h0B00, 0,0, 0,0, 0,0, "R11");
    // R11: LR together with SC
    cyc(1,16'h0C00, 0,0, 0,0, 0,0, 0,0, "R11");
    cyc(1,16'h0D00, 1,16'h0C00, 0,0, 0,0, 0,0, "R11");
    cyc(0,0, 1,16'h0D00, 0,0, 0,0, 0,0, "R11");
    idle("R12");
    // random stream over a few blocks to collide events
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      cyc((r & 3) == 0, ($urandom % 4) << OFS | ($urandom % 16),
          ((r >> 2) & 3) == 0, ($urandom % 4) << OFS,
          ((r >> 4) & 7) == 0, ($urandom % 4) << OFS,
          ((r >> 7) & 7) == 0, ($urandom % 4) << OFS,
          ((r >> 10) & 31) == 0, ((r >> 15) & 31) == 0, "R8/RND");
    end
    finished = 1;
    report();
  end
endmodule